// File: doc/BRIEF.md
# Video RAM Row/Serial Transfer Controller

This block sits between the random-access array of a dual-port video memory and its serial access register (a 512-entry, 4-bit wide shift store with a movable start point). All controls are sampled on the block clock. When the active-low row strobe falls, the block classifies the cycle from the levels of the transfer-gate, write, special-function and serial-enable inputs, and it latches the shared 9-bit address as a row number. When the column strobe falls later in the same cycle, the address is latched again as the serial start tap.

A read transfer copies an array row into the serial register when the transfer gate returns high. This lets a caller finish shifting out the previous line first. Normal and alternate write transfers copy the serial register into the latched row. A pseudo-write moves no data. It only turns the serial port into an input and sets the start tap. Each rising serial clock moves the serial pointer by one tap, and the pointer wraps at the end of the register. The array depth is a parameter, so the behavioural model stays small.

Top module: `vram_xfer_ctrl`

## Requirements
- R1: After reset, cycle_o is 0 (no transfer), port_in_o is 0 (output mode), ser_ptr_o is 0 and ser_d_o is 0.
- R2: On a row-strobe fall, cycle_o takes the decoded type, visible one clock later, and holds it until the next row-strobe fall. The decode is: transfer gate high gives 0 (none). Gate low with write high gives 1 (read). Gate low, write low and serial-enable high gives 4 (pseudo-write). Gate low, write low, serial-enable low and special-function high gives 3 (alternate write). Otherwise the type is 2 (normal write).
- R3: A pseudo-write changes no serial-register or array data, and its row address has no effect. On the column-strobe fall it sets port_in_o to 1 and loads ser_ptr_o with the column address.
- R4: A normal or alternate write transfer copies the whole serial register into the array row on the column-strobe fall. It sets port_in_o to 1 and loads ser_ptr_o with the column address.
- R5: A read transfer latches its tap on the column-strobe fall but changes nothing until the transfer gate rises. On that rise the addressed row is loaded into the serial register, port_in_o goes to 0 and ser_ptr_o takes the latched tap.
- R6: Each rising edge of ser_clk_i advances ser_ptr_o by one, and tap 511 is followed by tap 0.
- R7: In output mode, ser_d_o shows the nibble at ser_ptr_o. In input mode, ser_d_o is 0 and each serial clock writes ser_d_i into the tap it leaves.
- R8: The array row used is the latched row address modulo ROWS.
- R9: A cycle whose column strobe never falls moves no data and leaves ser_ptr_o and port_in_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_stb_ni | input | 1 | Row strobe, active low |
| col_stb_ni | input | 1 | Column strobe, active low |
| xfer_gate_ni | input | 1 | Transfer gate, active low |
| wr_ni | input | 1 | Write control, active low |
| spec_fn_i | input | 1 | Special-function select |
| ser_en_i | input | 1 | Serial-enable control, selects pseudo-write |
| addr_i | input | 9 | Shared row/column address |
| ser_clk_i | input | 1 | Serial clock, rising edge active |
| ser_d_i | input | 4 | Serial data in |
| ser_d_o | output | 4 | Serial data out |
| cycle_o | output | 3 | Decoded cycle type |
| port_in_o | output | 1 | 1 when the serial port is in input mode |
| ser_ptr_o | output | 9 | Current serial tap |

## Verification
The assertions assume that every strobe, gate and serial clock level is held for at least one clock. They also assume the column strobe falls only while the row strobe is already low. The bench meets this by changing inputs on the falling clock edge, one event per clock. It keeps the serial clock low during every transfer event, so a pointer step never competes with a tap load.

// File: rtl/vram_xfer_pkg.sv
package vram_xfer_pkg;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned TAPS   = 512;
  localparam int unsigned DW     = 4;

  typedef enum logic [2:0] {
    XF_NONE   = 3'd0,
    XF_READ   = 3'd1,
    XF_NWRITE = 3'd2,
    XF_AWRITE = 3'd3,
    XF_PSEUDO = 3'd4
  } xfer_e;
endpackage

// File: rtl/vram_xfer_decode.sv
module vram_xfer_decode
  import vram_xfer_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          row_stb_ni,
  input  logic          col_stb_ni,
  input  logic          xfer_gate_ni,
  input  logic          wr_ni,
  input  logic          spec_fn_i,
  input  logic          ser_en_i,
  input  logic [AW-1:0] addr_i,
  output xfer_e         cycle_o,
  output logic [AW-1:0] row_o,
  output logic [AW-1:0] tap_o,
  output logic          wr_xfer_o,
  output logic          pseudo_o,
  output logic          rd_commit_o
);
  logic row_prev_q, col_prev_q, gate_prev_q, rd_pend_q;
  logic row_fall, col_fall, gate_rise;
  xfer_e cyc_q, cyc_d;
  logic [AW-1:0] row_q, tap_q;

  assign row_fall  = !row_stb_ni && row_prev_q;
  // column edge only counts inside an already-open row cycle
  assign col_fall  = !col_stb_ni && col_prev_q && !row_prev_q;
  assign gate_rise = xfer_gate_ni && !gate_prev_q;

  always_comb begin
    if (xfer_gate_ni)   cyc_d = XF_NONE;
    else if (wr_ni)     cyc_d = XF_READ;
    else if (ser_en_i)  cyc_d = XF_PSEUDO;
    else if (spec_fn_i) cyc_d = XF_AWRITE;
    else                cyc_d = XF_NWRITE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_prev_q  <= 1'b1;
      col_prev_q  <= 1'b1;
      gate_prev_q <= 1'b1;
      cyc_q       <= XF_NONE;
      row_q       <= '0;
      tap_q       <= '0;
      rd_pend_q   <= 1'b0;
    end else begin
      row_prev_q  <= row_stb_ni;
      col_prev_q  <= col_stb_ni;
      gate_prev_q <= xfer_gate_ni;
      if (row_fall) begin
        cyc_q     <= cyc_d;
        row_q     <= addr_i;
        rd_pend_q <= 1'b0;
      end else if (col_fall) begin
        tap_q     <= addr_i;
        rd_pend_q <= (cyc_q == XF_READ);
      end else if (gate_rise && rd_pend_q) begin
        rd_pend_q <= 1'b0;
      end
    end
  end

  assign cycle_o     = cyc_q;
  assign row_o       = row_q;
  assign tap_o       = col_fall ? addr_i : tap_q;
  assign wr_xfer_o   = col_fall && (cyc_q == XF_NWRITE || cyc_q == XF_AWRITE);
  assign pseudo_o    = col_fall && (cyc_q == XF_PSEUDO);
  assign rd_commit_o = gate_rise && rd_pend_q;

  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_xfer_o, pseudo_o, rd_commit_o})) else $error("action overlap"); // R2
  AST_CYCLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_fall |=> $stable(cyc_q)) else $error("cycle type changed"); // R2
  AST_READ_WAITS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_commit_o |-> (cyc_q == XF_READ)) else $error("commit outside read"); // R5
endmodule

// File: rtl/vram_sam.sv
module vram_sam #(
  parameter int unsigned TAPS = 512,
  parameter int unsigned DW   = 4,
  localparam int unsigned PW  = $clog2(TAPS),
  localparam int unsigned W   = TAPS * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [W-1:0]  load_data_i,
  input  logic          set_in_i,
  input  logic [PW-1:0] ptr_val_i,
  input  logic          step_i,
  input  logic [DW-1:0] din_i,
  output logic [W-1:0]  data_o,
  output logic [PW-1:0] ptr_o,
  output logic          port_in_o,
  output logic [DW-1:0] dout_o
);
  logic [W-1:0]  data_q;
  logic [PW-1:0] ptr_q, ptr_nx;
  logic          in_q;

  assign ptr_nx = (ptr_q == PW'(TAPS - 1)) ? '0 : ptr_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ptr_q  <= '0;
      in_q   <= 1'b0;
    end else if (load_i) begin
      data_q <= load_data_i;
      ptr_q  <= ptr_val_i;
      in_q   <= 1'b0;
    end else if (set_in_i) begin
      ptr_q  <= ptr_val_i;
      in_q   <= 1'b1;
    end else if (step_i) begin
      if (in_q) data_q[ptr_q*DW +: DW] <= din_i;
      ptr_q <= ptr_nx;
    end
  end

  assign data_o    = data_q;
  assign ptr_o     = ptr_q;
  assign port_in_o = in_q;
  assign dout_o    = in_q ? '0 : data_q[ptr_q*DW +: DW];

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !set_in_i && ptr_q == PW'(TAPS - 1) |=> ptr_q == '0)
    else $error("pointer wrap"); // R6
  AST_INPUT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_in_i && !load_i |=> in_q && $stable(data_q)) else $error("input switch"); // R3
  AST_LOAD_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !in_q) else $error("load direction"); // R5
  AST_OUT_STEP_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !in_q && !load_i && !set_in_i |=> $stable(data_q)) else $error("output step wrote"); // R7
endmodule

// File: rtl/vram_row_array.sv
module vram_row_array #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned AW   = 9,
  parameter int unsigned W    = 2048,
  localparam int unsigned RAW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] row_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0]   mem_q [ROWS];
  logic [RAW-1:0] idx;

  assign idx = RAW'(row_i % AW'(ROWS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ROWS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[idx];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(idx)] == $past(wr_data_i)) else $error("row write lost"); // R4
endmodule

// File: rtl/vram_xfer_ctrl.sv
module vram_xfer_ctrl
  import vram_xfer_pkg::*;
#(
  parameter int unsigned ROWS = 4,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned NTAP = TAPS,
  parameter int unsigned BW   = DW,
  localparam int unsigned PW  = $clog2(NTAP),
  localparam int unsigned W   = NTAP * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          row_stb_ni,
  input  logic          col_stb_ni,
  input  logic          xfer_gate_ni,
  input  logic          wr_ni,
  input  logic          spec_fn_i,
  input  logic          ser_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ser_clk_i,
  input  logic [BW-1:0] ser_d_i,
  output logic [BW-1:0] ser_d_o,
  output logic [2:0]    cycle_o,
  output logic          port_in_o,
  output logic [PW-1:0] ser_ptr_o
);
  xfer_e         cyc;
  logic [AW-1:0] row, tap;
  logic          wr_xfer, pseudo, rd_commit;
  logic          sclk_prev_q, sclk_rise;
  logic [W-1:0]  sam_data, row_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= ser_clk_i;
  end
  assign sclk_rise = ser_clk_i && !sclk_prev_q;

  vram_xfer_decode #(.AW(AW)) u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .row_stb_ni   (row_stb_ni),
    .col_stb_ni   (col_stb_ni),
    .xfer_gate_ni (xfer_gate_ni),
    .wr_ni        (wr_ni),
    .spec_fn_i    (spec_fn_i),
    .ser_en_i     (ser_en_i),
    .addr_i       (addr_i),
    .cycle_o      (cyc),
    .row_o        (row),
    .tap_o        (tap),
    .wr_xfer_o    (wr_xfer),
    .pseudo_o     (pseudo),
    .rd_commit_o  (rd_commit)
  );

  vram_sam #(.TAPS(NTAP), .DW(BW)) u_sam (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (rd_commit),
    .load_data_i (row_data),
    .set_in_i    (wr_xfer || pseudo),
    .ptr_val_i   (PW'(tap)),
    .step_i      (sclk_rise),
    .din_i       (ser_d_i),
    .data_o      (sam_data),
    .ptr_o       (ser_ptr_o),
    .port_in_o   (port_in_o),
    .dout_o      (ser_d_o)
  );

  vram_row_array #(.ROWS(ROWS), .AW(AW), .W(W)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_xfer),
    .row_i     (row),
    .wr_data_i (sam_data),
    .rd_data_o (row_data)
  );

  assign cycle_o = cyc;

  AST_PSEUDO_NO_ARRAY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pseudo |-> !wr_xfer) else $error("pseudo wrote array"); // R3
  AST_WRITE_SETS_TAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_xfer |=> port_in_o && ser_ptr_o == $past(PW'(addr_i))) else $error("write tap"); // R4
  AST_QUIET_IN_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_in_o |-> ser_d_o == '0) else $error("output driven in input mode"); // R7
endmodule

// File: tb/vram_xfer_ctrl_tb_top.sv
`timescale 1ns/1ps
module vram_xfer_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic row_n = 1'b1, col_n = 1'b1, gate_n = 1'b1, wr_n = 1'b1, sf = 1'b0, se = 1'b0;
  logic [8:0] addr = '0;
  logic sclk = 1'b0;
  logic [3:0] din = '0, dout;
  logic [2:0] cyc;
  logic port_in;
  logic [8:0] ptr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vram_xfer_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .row_stb_ni(row_n), .col_stb_ni(col_n),
    .xfer_gate_ni(gate_n), .wr_ni(wr_n), .spec_fn_i(sf), .ser_en_i(se),
    .addr_i(addr), .ser_clk_i(sclk), .ser_d_i(din), .ser_d_o(dout),
    .cycle_o(cyc), .port_in_o(port_in), .ser_ptr_o(ptr)
  );

  // {gate_n, wr_n, spec_fn, ser_en, expected cycle}
  localparam logic [6:0] VEC [8] = '{
    {4'b1000, 3'd0}, {4'b1011, 3'd0}, {4'b0100, 3'd1}, {4'b0111, 3'd1},
    {4'b0000, 3'd2}, {4'b0010, 3'd3}, {4'b0001, 3'd4}, {4'b0011, 3'd4}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start(input logic g, input logic w, input logic f, input logic s, input logic [8:0] r);
    gate_n = g; wr_n = w; sf = f; se = s; addr = r; row_n = 1'b0;
    @(negedge clk);
  endtask
  task automatic col(input logic [8:0] t);
    addr = t; col_n = 1'b0;
    @(negedge clk);
  endtask
  task automatic gate_up();
    gate_n = 1'b1;
    @(negedge clk);
  endtask
  task automatic close();
    row_n = 1'b1; col_n = 1'b1; gate_n = 1'b1; wr_n = 1'b1; sf = 1'b0; se = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask
  task automatic pulse(input logic [3:0] d);
    din = d; sclk = 1'b1;
    @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cyc, 0, "R1 cycle");
    chk(port_in, 0, "R1 port");
    chk(ptr, 0, "R1 ptr");
    chk(dout, 0, "R1 dout");

    // R2 decode table, R9 no column edge means no action
    for (int i = 0; i < 8; i++) begin
      start(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], 9'd2);
      chk(cyc, VEC[i][2:0], $sformatf("R2 vec%0d", i));
      if (VEC[i][6] == 1'b0 && VEC[i][5] == 1'b1) gate_up();
      close();
      chk({port_in, ptr}, 0, $sformatf("R9 vec%0d", i));
    end

    // R3 pseudo-write: input mode, tap from column address
    start(0, 0, 0, 1, 9'd3);
    col(9'd510);
    chk(cyc, 4, "R3 cycle");
    chk(port_in, 1, "R3 port");
    chk(ptr, 510, "R3 ptr");
    chk(dout, 0, "R7 quiet in input mode");
    close();

    // R6 wrap while shifting in, R7 write of serial data
    pulse(4'hA); pulse(4'hB);
    chk(ptr, 0, "R6 wrap");
    pulse(4'hC); pulse(4'hD);
    chk(ptr, 2, "R6 advance");

    // R4 normal write to row 2
    start(0, 0, 0, 0, 9'd2);
    col(9'd5);
    chk(cyc, 2, "R4 cycle");
    chk(ptr, 5, "R4 ptr");
    chk(port_in, 1, "R4 port");
    close();

    // R5 read row 2: nothing before gate rise
    start(0, 1, 0, 0, 9'd2);
    col(9'd510);
    chk(ptr, 5, "R5 ptr before gate");
    chk(port_in, 1, "R5 port before gate");
    gate_up();
    chk(port_in, 0, "R5 port");
    chk(ptr, 510, "R5 ptr");
    chk(dout, 4'hA, "R5 data");
    close();
    pulse(4'h0);
    chk(dout, 4'hB, "R7 tap511");
    pulse(4'h0);
    chk({ptr, dout}, {9'd0, 4'hC}, "R6 R7 wrap out");
    pulse(4'h0);
    chk(dout, 4'hD, "R7 tap1");

    // R3 pseudo with row 3 then shift E into tap 0
    start(0, 0, 0, 1, 9'd3);
    col(9'd0);
    close();
    pulse(4'hE);
    // R4 alternate write to row 6 (R8: aliases row 2)
    start(0, 0, 1, 0, 9'd6);
    col(9'd0);
    chk(cyc, 3, "R4 alt cycle");
    close();
    start(0, 1, 0, 0, 9'd2);
    col(9'd0);
    gate_up();
    close();
    chk(dout, 4'hE, "R8 alias row");
    // row 3 untouched by pseudo cycles
    start(0, 1, 0, 0, 9'd3);
    col(9'd510);
    gate_up();
    close();
    chk(dout, 0, "R3 row ignored");

    // R9 read without column edge
    start(0, 1, 0, 0, 9'd2);
    gate_up();
    close();
    chk({port_in, ptr}, {1'b0, 9'd510}, "R9 no column");
    chk(dout, 0, "R9 data kept");

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule